// File: doc/BRIEF.md
# Timed Two-Wire Serial Write Master

This block sends one byte to a peripheral over a two-wire control bus made of a serial clock line and a serial data line. A typical peripheral is an audio converter that takes its configuration this way. A request taken while the block is idle opens a frame with a start condition. The eight data bits follow, most significant bit first. A stop condition closes the frame, and a bus-free gap follows before the block reports completion.

All timing comes from one tick counter running on the fast system clock. No symmetric divider is used. The low phase, high phase, data setup, data hold, start hold, stop setup and bus-free time each have their own minimum in nanoseconds. Each minimum is turned into a tick count at elaboration, rounded up. The data line changes at a fixed tick offset after each clock fall, chosen so that the hold time after the previous rise is met. The low phase is stretched when it needs extra room to meet setup before the next rise.

Top module: `twowire_write_master`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `sclk_o` and `sdin_o` are both 1 and `done_o` is 0.
- R2: A request (`req_i` = 1) sampled while idle sets `busy_o` on the next clock. `sdin_o` falls in that same cycle while `sclk_o` stays 1 (start condition), and this is the only falling data edge with the clock high in the frame.
- R3: After the start condition, `sclk_o` stays high for at least the start-hold tick count (75 cycles at 125 MHz) before its first fall.
- R4: Every clock low phase inside a frame lasts at least the low-time tick count, which is the low time rounded up to whole cycles (1300 ns gives 163 cycles at 125 MHz).
- R5: Every data-bit high phase lasts at least the high-time tick count (75 cycles at 125 MHz).
- R6: Exactly eight data bits are transferred, most significant bit first. Each bit is the value of `sdin_o` at a rising edge of `sclk_o`, and the bits are taken from `byte_i` as captured with the request.
- R7: Within a frame, the data line changes only while `sclk_o` is low, except at start and stop. Every change comes at least the setup tick count (13 cycles) before the next clock rise.
- R8: A data change after a bit's clock rise comes at least the hold tick count (113 cycles) after that rise.
- R9: The stop condition is a rise of `sdin_o` while `sclk_o` is high. It comes at least the stop-setup tick count (75 cycles) after the last clock rise, and it happens exactly once per frame.
- R10: `busy_o` stays high for at least the bus-free tick count (163 cycles) after the stop condition. It then falls in the same cycle that `done_o` pulses high for exactly one cycle.
- R11: A request while `busy_o` is high is ignored. It alters neither the byte being sent nor the frame, and it is not queued as a later frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request to send one byte, taken only when idle |
| byte_i | input | W (8) | Byte to send, captured with the request |
| sclk_o | output | 1 | Serial clock line |
| sdin_o | output | 1 | Serial data line drive |
| busy_o | output | 1 | High from request acceptance to the end of the bus-free gap |
| done_o | output | 1 | One-cycle pulse when the frame is complete |

## Verification
The bench watches both bus lines with a cycle-counting monitor. It targets the places where an edge could be placed one tick too early. A design with the data-update offset off would break the hold window after the rise or the setup window before it. A design that shortened the low phase, or failed to round up, would fall short of 163 cycles. Patterns of all zeros, all ones, alternating bits and single-end bits expose shifting in the wrong order and a missing or extra bit. A request injected in mid-frame with the inverted byte catches a design that reloads its shift register or queues a second frame. Counting start and stop events catches a data edge placed while the clock is high.

// File: rtl/twowire_write_master.sv
module twowire_write_master #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int T_LOW_NS  = 1300,
  parameter int T_HIGH_NS = 600,
  parameter int T_SU_NS   = 100,
  parameter int T_HD_NS   = 900,
  parameter int T_STA_NS  = 600,
  parameter int T_STO_NS  = 600,
  parameter int T_BUF_NS  = 1300,
  parameter int W         = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic [W-1:0] byte_i,
  output logic         sclk_o,
  output logic         sdin_o,
  output logic         busy_o,
  output logic         done_o
);

  function automatic int to_ticks(input longint ns);
    longint t;
    t = (ns * longint'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000;
    return (t < 1) ? 1 : int'(t);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int HIGH_T = to_ticks(T_HIGH_NS);
  localparam int SU_T   = to_ticks(T_SU_NS);
  localparam int HD_T   = to_ticks(T_HD_NS);
  localparam int UPD_T  = (HD_T > HIGH_T) ? HD_T - HIGH_T : 0;
  localparam int LOW_T  = max2(to_ticks(T_LOW_NS), UPD_T + SU_T + 1);
  localparam int STA_T  = to_ticks(T_STA_NS);
  localparam int STO_T  = max2(to_ticks(T_STO_NS), HIGH_T);
  localparam int BUF_T  = to_ticks(T_BUF_NS);
  localparam int MAX_T  = max2(max2(LOW_T, STO_T), max2(max2(STA_T, BUF_T), HIGH_T));
  localparam int CW     = $clog2(MAX_T + 1);
  localparam int BW     = (W > 1) ? $clog2(W) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_LOW, S_HIGH, S_SLOW, S_SHIGH, S_FREE
  } phase_t;

  phase_t         st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bitn;
  logic [W-1:0]   shreg;

  wire at_upd  = (cnt == CW'(UPD_T));
  wire end_low = (cnt == CW'(LOW_T - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      sclk_o <= 1'b1;
      sdin_o <= 1'b1;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      cnt    <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (req_i) begin
            shreg  <= byte_i;
            bitn   <= '0;
            sdin_o <= 1'b0;
            busy_o <= 1'b1;
            st     <= S_START;
          end
        end
        S_START: if (cnt == CW'(STA_T - 1)) begin
          cnt    <= '0;
          sclk_o <= 1'b0;
          st     <= S_LOW;
        end
        S_LOW: begin
          if (at_upd) sdin_o <= shreg[W-1];
          if (end_low) begin
            cnt    <= '0;
            sclk_o <= 1'b1;
            st     <= S_HIGH;
          end
        end
        S_HIGH: if (cnt == CW'(HIGH_T - 1)) begin
          cnt    <= '0;
          sclk_o <= 1'b0;
          shreg  <= shreg << 1;
          if (bitn == BW'(W - 1)) st <= S_SLOW;
          else begin
            bitn <= bitn + 1'b1;
            st   <= S_LOW;
          end
        end
        S_SLOW: begin
          if (at_upd) sdin_o <= 1'b0;
          if (end_low) begin
            cnt    <= '0;
            sclk_o <= 1'b1;
            st     <= S_SHIGH;
          end
        end
        S_SHIGH: if (cnt == CW'(STO_T - 1)) begin
          cnt    <= '0;
          sdin_o <= 1'b1;
          st     <= S_FREE;
        end
        S_FREE: if (cnt == CW'(BUF_T - 1)) begin
          cnt    <= '0;
          busy_o <= 1'b0;
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/twowire_write_master_chk.sv
module twowire_write_master_chk #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int T_LOW_NS  = 1300,
  parameter int T_HIGH_NS = 600
) (
  input logic clk,
  input logic rst_n,
  input logic req_i,
  input logic sclk_o,
  input logic sdin_o,
  input logic busy_o,
  input logic done_o
);

  function automatic int ceil_ticks(input longint ns);
    return int'((ns * longint'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  localparam int LOW_MIN  = ceil_ticks(T_LOW_NS);
  localparam int HIGH_MIN = ceil_ticks(T_HIGH_NS);

  int lowc, highc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowc  <= 0;
      highc <= 0;
    end else begin
      lowc  <= sclk_o ? 0 : ((lowc  < 32'h3fff_ffff) ? lowc  + 1 : lowc);
      highc <= sclk_o ? ((highc < 32'h3fff_ffff) ? highc + 1 : highc) : 0;
    end
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (sclk_o && sdin_o));

  a_r2_request_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i) |=> (busy_o && sclk_o && !sdin_o));

  a_r4_low_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk_o) && busy_o) |-> (lowc >= LOW_MIN));

  a_r5_high_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (highc >= HIGH_MIN));

  a_r7_no_fall_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && sclk_o && $past(sclk_o)) |-> !$fell(sdin_o));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

bind twowire_write_master twowire_write_master_chk #(
  .CLK_HZ(CLK_HZ), .T_LOW_NS(T_LOW_NS), .T_HIGH_NS(T_HIGH_NS)
) chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .sclk_o(sclk_o),
  .sdin_o(sdin_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/twowire_write_master_test.sv
`timescale 1ns/1ps
module twowire_write_master_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       sclk, sdin, busy, done;

  always #4 clk = ~clk;

  twowire_write_master uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .byte_i(byte_in),
    .sclk_o(sclk), .sdin_o(sdin), .busy_o(busy), .done_o(done)
  );

  function automatic int need(input int ns);
    return (ns + 7) / 8;
  endfunction

  localparam int BIG = 1 << 30;

  int checks = 0, errors = 0, cyc = 0;
  int t_rise, t_fall, t_chg, t_start, t_stop;
  int min_low, min_high, min_su, min_hd, sta_hold, sto_setup, buf_gap;
  int n_start, n_stop, n_bits, n_bad, done_cnt;
  logic [7:0] cap;
  logic prev_sclk = 1'b1, prev_sdin = 1'b1, in_frame, first_fall;

  task automatic mon_clear();
    min_low = BIG; min_high = BIG; min_su = BIG; min_hd = BIG;
    sta_hold = -1; sto_setup = -1; buf_gap = -1;
    n_start = 0; n_stop = 0; n_bits = 0; n_bad = 0; done_cnt = 0;
    cap = 8'h00; in_frame = 1'b0; first_fall = 1'b0;
    t_rise = 0; t_fall = 0; t_chg = 0; t_start = 0; t_stop = 0;
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (sclk != prev_sclk && sdin != prev_sdin) n_bad = n_bad + 1;
      else if (sclk != prev_sclk) begin
        if (!sclk) begin
          if (in_frame && first_fall) begin
            sta_hold = cyc - t_start;
            first_fall = 1'b0;
          end else if (in_frame && (cyc - t_rise) < min_high) min_high = cyc - t_rise;
          t_fall = cyc;
        end else begin
          if (in_frame) begin
            if ((cyc - t_fall) < min_low) min_low = cyc - t_fall;
            if ((cyc - t_chg) < min_su) min_su = cyc - t_chg;
            if (n_bits < 8) begin
              cap = {cap[6:0], sdin};
              n_bits = n_bits + 1;
            end
          end
          t_rise = cyc;
        end
      end else if (sdin != prev_sdin) begin
        if (sclk) begin
          if (!sdin) begin
            n_start = n_start + 1;
            in_frame = 1'b1;
            first_fall = 1'b1;
            t_start = cyc;
          end else begin
            n_stop = n_stop + 1;
            sto_setup = cyc - t_rise;
            in_frame = 1'b0;
            t_stop = cyc;
          end
        end else if (n_bits > 0 && (cyc - t_rise) < min_hd) min_hd = cyc - t_rise;
        t_chg = cyc;
      end
      if (done) begin
        done_cnt = done_cnt + 1;
        buf_gap = cyc - t_stop;
      end
    end
    prev_sclk = sclk;
    prev_sdin = sdin;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (4) tick();
    chk(sclk && sdin && !busy && !done, "R1 reset lines", {sclk, sdin, busy, done}, 4'b1100);
    rst_n = 1'b1;
    repeat (20) tick();
    chk(sclk && sdin && !busy && !done, "R1 idle lines", {sclk, sdin, busy, done}, 4'b1100);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit inject);
    int waited;
    mon_clear();
    req = 1'b1;
    byte_in = b;
    tick();
    req = 1'b0;
    byte_in = ~b;
    chk(busy && sclk && !sdin, "R2 start condition", {busy, sclk, sdin}, 3'b110);
    if (inject) begin
      repeat (600) tick();
      req = 1'b1;
      tick();
      req = 1'b0;
    end
    waited = 0;
    while (!done && waited < 6000) begin
      tick();
      waited = waited + 1;
    end
    chk(done == 1'b1, "R10 done reached", done, 1);
    chk(!busy, "R10 busy falls with done", busy, 0);
    chk(cap == b, "R6 byte MSB first", cap, b);
    chk(n_bits == 8, "R6 bit count", n_bits, 8);
    chk(n_start == 1, "R2 single start", n_start, 1);
    chk(n_bad == 0, "R7 simultaneous edges", n_bad, 0);
    chk(sta_hold >= need(600), "R3 start hold", sta_hold, need(600));
    chk(min_low >= need(1300), "R4 low phase", min_low, need(1300));
    chk(min_high >= need(600), "R5 high phase", min_high, need(600));
    chk(min_su >= need(100), "R7 data setup", min_su, need(100));
    chk(min_hd >= need(900), "R8 data hold", min_hd, need(900));
    chk(n_stop == 1, "R9 single stop", n_stop, 1);
    chk(sto_setup >= need(600), "R9 stop setup", sto_setup, need(600));
    tick();
    chk(buf_gap >= need(1300), "R10 bus free gap", buf_gap, need(1300));
    chk(!done && done_cnt == 1, "R10 done one cycle", done_cnt, 1);
    if (inject) begin
      repeat (400) tick();
      chk(n_start == 1 && sclk && sdin && !busy, "R11 request while busy not queued",
          n_start, 1);
    end
  endtask

  initial begin
    mon_clear();
    test_reset();
    send_frame(8'hA5, 1'b1);
    send_frame(8'h00, 1'b0);
    send_frame(8'hFF, 1'b0);
    send_frame(8'h3C, 1'b1);
    send_frame(8'h81, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule